// File: doc/BRIEF.md
# Single-Accumulator Multi-Cycle Processor Core

This block is a small processor that keeps all arithmetic results in one 16-bit accumulator. Program and data share a single 4096 x 16 word store inside the block. Each instruction passes through a state machine one state per clock. The machine fetches the word, decodes it, and follows the pointer when the instruction asks for indirection. It then reads, modifies or writes the operand word. Seven memory-reference operations are provided: bitwise AND, addition with carry-out, load, store, jump, call with link, and increment-and-skip-on-zero. One further operation code stops the core.

Software loads the store through a dedicated write port while the core is held in reset. Releasing reset starts execution at address 0. The accumulator, program counter, carry flag and a halt indication are visible at the ports. A test environment can therefore judge a program by the state it leaves behind.

Top module: `accum_core`

## Requirements
- R1: While rst_n is low the accumulator, program counter and carry flag read 0 and halted is low.
- R2: An instruction word is split as bit 15 = mode (0 direct, 1 indirect), bits 14..12 = operation, bits 11..0 = address. After each fetch the program counter points at the following word.
- R3: With mode 1, the word at the 12-bit address field is read and its low 12 bits become the operand address.
- R4: Operation 000 puts (AC AND M) in AC, operation 001 puts the low 16 bits of AC + M in AC, and operation 010 copies M into AC. M is the word at the operand address.
- R5: Operation 001 sets the carry flag to bit 16 of the sum, and operation 000 leaves the carry flag unchanged.
- R6: Operation 011 writes AC into the word at the operand address.
- R7: Operation 100 loads the program counter with the operand address.
- R8: Operation 101 writes the address of the following instruction, zero-extended, into the word at the operand address, then continues at operand address + 1.
- R9: Operation 110 writes M + 1 back to the operand address. When that result is 0 the next instruction is skipped.
- R10: Operation 111 raises halted, which stays high with the program counter frozen until reset.
- R11: While rst_n is low, a high load_en writes load_data into the store at load_addr on each rising clock edge. Execution starts at address 0 when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset; also enables preload |
| load_en | input | 1 | Preload write strobe, honoured only in reset |
| load_addr | input | 12 | Preload word address |
| load_data | input | 16 | Preload word value |
| halted | output | 1 | High once the stop operation has executed |
| ac_obs | output | 16 | Accumulator value |
| pc_obs | output | 12 | Program counter value |
| carry_obs | output | 1 | Carry flag from the last addition |

## Verification
The bench builds the core with its default widths: a 16-bit word and a 12-bit address. These widths put the 16-bit carry boundary within reach, and so is the all-ones word that wraps to zero under increment-and-skip. Pointer words and link words placed far from the code are reachable too. Each preloaded program ends in the stop operation. Stores, links and increments leave results in memory, and each program reads those words back into the accumulator. The checks on AC, PC and carry then cover them.

// File: rtl/accum_pkg.sv
`timescale 1ns/1ps
package accum_pkg;

  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_ADD = 3'b001,
    OP_LDA = 3'b010,
    OP_STA = 3'b011,
    OP_BUN = 3'b100,
    OP_BSA = 3'b101,
    OP_ISZ = 3'b110,
    OP_HLT = 3'b111
  } op_e;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_FWAIT,
    ST_DECODE,
    ST_IND,
    ST_IWAIT,
    ST_EXEC,
    ST_RWAIT,
    ST_WBACK,
    ST_HALT
  } state_e;

  // True for operations that must read the operand word before acting.
  function automatic logic op_reads_mem(op_e op);
    return (op == OP_AND) || (op == OP_ADD) || (op == OP_LDA) || (op == OP_ISZ);
  endfunction

endpackage

// File: rtl/accum_ram.sv
`timescale 1ns/1ps
module accum_ram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/accum_alu.sv
`timescale 1ns/1ps
module accum_alu
  import accum_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] ac_in,
  input  logic [DATA_W-1:0] mem_in,
  input  logic              e_in,
  output logic [DATA_W-1:0] ac_out,
  output logic              e_out,
  output logic [DATA_W-1:0] inc_out
);
  function automatic logic [DATA_W:0] f_sum(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic [DATA_W-1:0] f_inc(logic [DATA_W-1:0] a);
    return a + {{(DATA_W-1){1'b0}}, 1'b1};
  endfunction

  logic [DATA_W:0] sum;
  assign sum     = f_sum(ac_in, mem_in);
  assign inc_out = f_inc(mem_in);

  always_comb begin
    ac_out = ac_in;
    e_out  = e_in;
    unique case (op)
      OP_AND: ac_out = ac_in & mem_in;
      OP_ADD: begin
        ac_out = sum[DATA_W-1:0];
        e_out  = sum[DATA_W];
      end
      OP_LDA: ac_out = mem_in;
      default: ;
    endcase
  end
endmodule

// File: rtl/accum_ctrl.sv
`timescale 1ns/1ps
module accum_ctrl
  import accum_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  op_e    op,
  input  logic   ind,
  output state_e state
);
  state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_FETCH:  nxt = ST_FWAIT;
      ST_FWAIT:  nxt = ST_DECODE;
      ST_DECODE: begin
        if (op == OP_HLT) nxt = ST_HALT;
        else if (ind)     nxt = ST_IND;
        else              nxt = ST_EXEC;
      end
      ST_IND:    nxt = ST_IWAIT;
      ST_IWAIT:  nxt = ST_EXEC;
      ST_EXEC:   nxt = op_reads_mem(op) ? ST_RWAIT : ST_FETCH;
      ST_RWAIT:  nxt = (op == OP_ISZ) ? ST_WBACK : ST_FETCH;
      ST_WBACK:  nxt = ST_FETCH;
      ST_HALT:   nxt = ST_HALT;
      default:   nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_FETCH;
    else        state <= nxt;
  end
endmodule

// File: rtl/accum_core.sv
`timescale 1ns/1ps
module accum_core
  import accum_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  output logic              halted,
  output logic [DATA_W-1:0] ac_obs,
  output logic [ADDR_W-1:0] pc_obs,
  output logic              carry_obs
);
  localparam int OP_LSB   = ADDR_W;
  localparam int MODE_BIT = DATA_W - 1;
  localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};

  state_e            state;
  logic [DATA_W-1:0] ac_q, ir_q, dr_q;
  logic [ADDR_W-1:0] pc_q, ar_q;
  logic              e_q;

  logic [DATA_W-1:0] rdata;
  logic [ADDR_W-1:0] raddr;
  logic              core_we;
  logic [DATA_W-1:0] core_wdata;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata;

  op_e               op;
  logic              ind;
  logic [DATA_W-1:0] alu_ac;
  logic              alu_e;
  logic [DATA_W-1:0] inc_val;

  // Named events for the checker.
  logic ir_load, and_done, add_done, bsa_go, bun_go, isz_skip;
  logic sta_we, bsa_we, isz_we;
  logic [ADDR_W-1:0] eff_addr;

  assign op  = op_e'(ir_q[OP_LSB +: 3]);
  assign ind = ir_q[MODE_BIT];

  accum_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .ind   (ind),
    .state (state)
  );

  accum_alu #(.DATA_W(DATA_W)) u_alu (
    .op      (op),
    .ac_in   (ac_q),
    .mem_in  (rdata),
    .e_in    (e_q),
    .ac_out  (alu_ac),
    .e_out   (alu_e),
    .inc_out (inc_val)
  );

  assign ir_load  = (state == ST_FWAIT);
  assign and_done = (state == ST_RWAIT) && (op == OP_AND);
  assign add_done = (state == ST_RWAIT) && (op == OP_ADD);
  assign bsa_go   = (state == ST_EXEC) && (op == OP_BSA);
  assign bun_go   = (state == ST_EXEC) && (op == OP_BUN);
  assign isz_skip = (state == ST_WBACK) && (dr_q == '0);
  assign sta_we   = (state == ST_EXEC) && (op == OP_STA);
  assign bsa_we   = bsa_go;
  assign isz_we   = (state == ST_WBACK);
  assign eff_addr = ar_q;

  assign raddr   = (state == ST_FETCH) ? pc_q : ar_q;
  assign core_we = sta_we | bsa_we | isz_we;

  always_comb begin
    core_wdata = dr_q;
    if (sta_we)      core_wdata = ac_q;
    else if (bsa_we) core_wdata = {{(DATA_W-ADDR_W){1'b0}}, pc_q};
  end

  // Preload owns the write port while the core is in reset.
  assign ram_we    = rst_n ? core_we : load_en;
  assign ram_waddr = rst_n ? ar_q : load_addr;
  assign ram_wdata = rst_n ? core_wdata : load_data;

  accum_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (raddr),
    .rdata (rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac_q <= '0;
      ir_q <= '0;
      dr_q <= '0;
      pc_q <= '0;
      ar_q <= '0;
      e_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_FETCH:  ar_q <= pc_q;
        ST_FWAIT: begin
          ir_q <= rdata;
          pc_q <= pc_q + ONE_A;
        end
        ST_DECODE: ar_q <= ir_q[ADDR_W-1:0];
        ST_IWAIT:  ar_q <= rdata[ADDR_W-1:0];
        ST_EXEC: begin
          if (bun_go)      pc_q <= ar_q;
          else if (bsa_go) pc_q <= ar_q + ONE_A;
        end
        ST_RWAIT: begin
          if (op == OP_ISZ) dr_q <= inc_val;
          else begin
            ac_q <= alu_ac;
            e_q  <= alu_e;
          end
        end
        ST_WBACK: if (isz_skip) pc_q <= pc_q + ONE_A;
        default: ;
      endcase
    end
  end

  assign halted    = (state == ST_HALT);
  assign ac_obs    = ac_q;
  assign pc_obs    = pc_q;
  assign carry_obs = e_q;
endmodule

// File: rtl/accum_chk.sv
`timescale 1ns/1ps
module accum_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              halted,
  input logic [DATA_W-1:0] ac_obs,
  input logic [ADDR_W-1:0] pc_obs,
  input logic              carry_obs,
  input logic              ir_load,
  input logic              and_done,
  input logic              bsa_go,
  input logic              bun_go,
  input logic              isz_skip,
  input logic              sta_we,
  input logic              bsa_we,
  input logic              isz_we,
  input logic [ADDR_W-1:0] eff_addr
);
  localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (ac_obs == '0 && pc_obs == '0 && !carry_obs && !halted));

  a_r2_fetch_step: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> pc_obs == $past(pc_obs) + ONE_A);

  a_r5_and_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
    and_done |=> carry_obs == $past(carry_obs));

  a_r6_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sta_we, bsa_we, isz_we}));

  a_r7_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    bun_go |=> pc_obs == $past(eff_addr));

  a_r8_link_entry: assert property (@(posedge clk) disable iff (!rst_n)
    bsa_go |=> pc_obs == $past(eff_addr) + ONE_A);

  a_r9_skip_step: assert property (@(posedge clk) disable iff (!rst_n)
    isz_skip |=> pc_obs == $past(pc_obs) + ONE_A);

  a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(pc_obs) && $stable(ac_obs));
endmodule

bind accum_core accum_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_accum_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .halted    (halted),
  .ac_obs    (ac_obs),
  .pc_obs    (pc_obs),
  .carry_obs (carry_obs),
  .ir_load   (ir_load),
  .and_done  (and_done),
  .bsa_go    (bsa_go),
  .bun_go    (bun_go),
  .isz_skip  (isz_skip),
  .sta_we    (sta_we),
  .bsa_we    (bsa_we),
  .isz_we    (isz_we),
  .eff_addr  (eff_addr)
);

// File: tb/test_accum_core.sv
`timescale 1ns/1ps
module test_accum_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [11:0] load_addr = '0;
  logic [15:0] load_data = '0;
  logic        halted;
  logic [15:0] ac_obs;
  logic [11:0] pc_obs;
  logic        carry_obs;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [15:0] ac;
    logic [11:0] pc;
    logic        e;
    string       tag;
  } exp_t;

  exp_t exp_q[$];

  always #2 clk = ~clk;

  accum_core i_accum_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_addr (load_addr),
    .load_data (load_data),
    .halted    (halted),
    .ac_obs    (ac_obs),
    .pc_obs    (pc_obs),
    .carry_obs (carry_obs)
  );

  // Instruction word builder: mode bit 15, operation 14..12, address 11..0.
  function automatic logic [15:0] ins(bit i, int op, int a);
    return {i, op[2:0], a[11:0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic poke(int a, logic [15:0] d);
    @(negedge clk);
    load_en   = 1'b1;
    load_addr = a[11:0];
    load_data = d;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Driver: push expectation, release reset, wait for monitor to consume it.
  task automatic run(exp_t e);
    int guard;
    exp_q.push_back(e);
    @(negedge clk);
    rst_n = 1'b1;
    guard = 0;
    while (exp_q.size() != 0 && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    if (exp_q.size() != 0) begin
      void'(exp_q.pop_front());
      check({e.tag, " R10 no halt"}, 0, 1);
    end else begin
      repeat (4) @(negedge clk);
      check({e.tag, " R10 halted held"}, {31'd0, halted}, 1);
      check({e.tag, " R10 pc frozen"}, {20'd0, pc_obs}, {20'd0, e.pc});
    end
  endtask

  // Monitor: compare final state once the core stops.
  always @(negedge clk) begin
    if (rst_n && halted && exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      check({it.tag, " ac"}, {16'd0, ac_obs}, {16'd0, it.ac});
      check({it.tag, " pc"}, {20'd0, pc_obs}, {20'd0, it.pc});
      check({it.tag, " carry"}, {31'd0, carry_obs}, {31'd0, it.e});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state; R11 preload leaves the core idle
    check("R1 ac reset", {16'd0, ac_obs}, 0);
    check("R1 pc reset", {20'd0, pc_obs}, 0);
    check("R1 carry reset", {31'd0, carry_obs}, 0);
    check("R1 halted reset", {31'd0, halted}, 0);

    // R4 R5 R11: load, add with carry out, and (carry kept)
    poke(0, ins(0, 2, 'h100));
    poke(1, ins(0, 1, 'h101));
    poke(2, ins(0, 0, 'h102));
    poke(3, ins(0, 7, 0));
    poke('h100, 16'hF00F);
    poke('h101, 16'h1FF5);
    poke('h102, 16'h0FFF);
    check("R11 pc idle during preload", {20'd0, pc_obs}, 0);
    run('{ac: 16'h0004, pc: 12'd4, e: 1'b1, tag: "R4 R5 and-keeps-carry"});

    // R5: carry set, then cleared by a second addition
    hold_reset();
    poke(0, ins(0, 2, 'h100));
    poke(1, ins(0, 1, 'h101));
    poke(2, ins(0, 1, 'h102));
    poke(3, ins(0, 7, 0));
    poke('h100, 16'hF000);
    poke('h101, 16'hF000);
    poke('h102, 16'hE001);
    run('{ac: 16'hC001, pc: 12'd4, e: 1'b1, tag: "R5 carry chain"});

    hold_reset();
    poke('h102, 16'h0001);
    run('{ac: 16'hE001, pc: 12'd4, e: 1'b0, tag: "R5 carry cleared"});

    // R3: indirect load and add
    hold_reset();
    poke(0, ins(1, 2, 'h010));
    poke(1, ins(1, 1, 'h011));
    poke(2, ins(0, 7, 0));
    poke('h010, 16'h0200);
    poke('h011, 16'hF201);
    poke('h200, 16'h1234);
    poke('h201, 16'h0001);
    run('{ac: 16'h1235, pc: 12'd3, e: 1'b0, tag: "R3 indirect"});

    // R6 R7 R2: store, jump, read back
    hold_reset();
    poke(0, ins(0, 2, 'h100));
    poke(1, ins(0, 3, 'h101));
    poke(2, ins(0, 2, 'h102));
    poke(3, ins(0, 4, 'h008));
    poke(4, ins(0, 7, 0));
    poke(8, ins(0, 2, 'h101));
    poke(9, ins(0, 7, 0));
    poke('h100, 16'hBEEF);
    poke('h101, 16'h0000);
    poke('h102, 16'h0000);
    run('{ac: 16'hBEEF, pc: 12'h00A, e: 1'b0, tag: "R6 R7 R2 store-jump"});

    // R8 R3: call with link, read link, return through it
    hold_reset();
    poke(0, ins(0, 5, 'h020));
    poke(1, ins(0, 7, 0));
    poke('h020, 16'hFFFF);
    poke('h021, ins(0, 2, 'h020));
    poke('h022, ins(1, 4, 'h020));
    run('{ac: 16'h0001, pc: 12'd2, e: 1'b0, tag: "R8 call-return"});

    // R9: increment wraps to zero and skips
    hold_reset();
    poke(0, ins(0, 6, 'h100));
    poke(1, ins(0, 7, 0));
    poke(2, ins(0, 2, 'h100));
    poke(3, ins(0, 7, 0));
    poke('h100, 16'hFFFF);
    run('{ac: 16'h0000, pc: 12'd4, e: 1'b0, tag: "R9 skip on zero"});

    // R9: increment without skip
    hold_reset();
    poke(0, ins(0, 6, 'h100));
    poke(1, ins(0, 2, 'h100));
    poke(2, ins(0, 7, 0));
    poke(3, ins(0, 7, 0));
    poke('h100, 16'h0005);
    run('{ac: 16'h0006, pc: 12'd3, e: 1'b0, tag: "R9 no skip"});

    // R10 immediate stop at address 0
    hold_reset();
    poke(0, ins(1, 7, 'h123));
    run('{ac: 16'h0000, pc: 12'd1, e: 1'b0, tag: "R10 stop at entry"});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule